// File: doc/BRIEF.md
# Prefetch-Aware Re-Reference Replacement Set

This block keeps the replacement state of one set in a 16-way last-level cache. Every way holds a 2-bit re-reference prediction value: 0 means the line is expected back soon, 1 means moderately soon, 2 means far off and 3 means distant. The surrounding cache controller reports each lookup to the block. A lookup is a demand access or a prefetch, and it either hits (with the hit way given) or misses. On a hit, the block promotes the way. On a miss, it searches for a victim, ages the set as often as needed, fills the chosen way with an insertion value, and reports the victim way.

A mode input controls how prefetches are treated. In baseline mode they are handled like demand accesses. In miss mode, lines filled by a prefetch are inserted as distant, so that unused prefetched data leaves the cache first. In hit mode, a prefetch that hits does not promote its line. Both mode applies the two rules together. Valid bits from the tag array are sampled when a miss is accepted, and empty ways are used before any value-based choice.

Top module: `pa_rrip_set`

## Requirements
- R1: After a synchronous reset, every way's value reads 3, `busy` is low and `victim_valid` is low.
- R2: On a miss, if any way is marked invalid in `line_valid` (sampled when the miss is accepted), the lowest-numbered invalid way is the victim, whatever the values are.
- R3: On a miss with all ways valid, the victim is the lowest-numbered way whose value is 3.
- R4: If no valid way holds 3, every way's value rises by one per cycle until one reaches 3. With k such aging steps, `victim_valid` is high in the (k+2)-th cycle after the request cycle.
- R5: Each accepted miss gives exactly one `victim_valid` pulse, one cycle wide. `busy` is high from the cycle after acceptance until the pulse.
- R6: The filled way gets value 2 on a demand miss. On a prefetch miss it gets 3 when `mode` is 1 (miss mode) or 3 (both), and 2 when `mode` is 0 (baseline) or 2 (hit mode). Both `mode` and `req_prefetch` are sampled at acceptance.
- R7: In modes 0 and 1, any hit sets the hit way's value to 0 one cycle after the request. All other ways keep their values.
- R8: In modes 2 and 3, a demand hit sets the hit way to 0. A prefetch hit leaves every value unchanged.
- R9: A request presented while `busy` is high is ignored. It changes no value and produces no victim pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0 baseline, 1 miss mode, 2 hit mode, 3 both |
| req_valid | input | 1 | Lookup report valid |
| req_prefetch | input | 1 | 1 = prefetch, 0 = demand |
| req_hit | input | 1 | 1 = lookup hit |
| req_way | input | 4 | Hit way (used when `req_hit` is 1) |
| line_valid | input | 16 | Per-way valid bits from the tag array |
| busy | output | 1 | Victim search in progress |
| victim_valid | output | 1 | One-cycle pulse: victim reported |
| victim_way | output | 4 | Chosen victim way |
| rrpv_o | output | 32 | Per-way values, way w at bits [2w+1:2w] |

## Verification
The hardest case to reach is a miss that needs several aging steps before it finds a victim. That only happens when no valid way holds the distant value. The bench gets there by sending demand hits in baseline mode to all sixteen ways, which drives every value to 0. The next miss then needs three aging steps.

A mixed state follows from that search: one way is refilled at 2 and the other fifteen are promoted again. The following miss then needs one aging step, and the bench uses this to check that aging keeps the gaps between ways. The ignore rule is tested by sending a hit and a second miss while such a search is still busy.

// File: rtl/pa_rrip_pkg.sv
package pa_rrip_pkg;
  typedef enum logic [1:0] {
    MODE_BASE = 2'd0,
    MODE_MISS = 2'd1,
    MODE_HIT  = 2'd2,
    MODE_BOTH = 2'd3
  } pf_mode_e;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_SEARCH = 1'b1
  } srch_state_e;
endpackage

// File: rtl/pa_rrip_first.sv
module pa_rrip_first #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/pa_rrip_vsel.sv
module pa_rrip_vsel #(
  parameter int WAYS   = 16,
  parameter int RRPV_W = 2,
  parameter int WAY_W  = 4
) (
  input  logic [WAYS*RRPV_W-1:0] rrpv_flat,
  input  logic [WAYS-1:0]        valid,
  output logic                   found,
  output logic [WAY_W-1:0]       found_way,
  output logic                   need_age
);
  localparam logic [RRPV_W-1:0] MAXV = {RRPV_W{1'b1}};

  logic [WAYS-1:0]  distant;
  logic             inv_found, dist_found;
  logic [WAY_W-1:0] inv_idx, dist_idx;

  for (genvar g = 0; g < WAYS; g++) begin : g_dist
    assign distant[g] = valid[g] && (rrpv_flat[g*RRPV_W +: RRPV_W] == MAXV);
  end

  pa_rrip_first #(.N(WAYS), .IDX_W(WAY_W)) u_inv (
    .req(~valid), .found(inv_found), .idx(inv_idx)
  );
  pa_rrip_first #(.N(WAYS), .IDX_W(WAY_W)) u_dist (
    .req(distant), .found(dist_found), .idx(dist_idx)
  );

  always_comb begin
    found     = inv_found | dist_found;
    found_way = inv_found ? inv_idx : dist_idx;
    need_age  = !found;
  end
endmodule

// File: rtl/pa_rrip_array.sv
module pa_rrip_array #(
  parameter int WAYS   = 16,
  parameter int RRPV_W = 2,
  parameter int WAY_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   age_en,
  input  logic                   fill_en,
  input  logic [WAY_W-1:0]       fill_way,
  input  logic [RRPV_W-1:0]      fill_val,
  input  logic                   clr_en,
  input  logic [WAY_W-1:0]       clr_way,
  output logic [WAYS*RRPV_W-1:0] rrpv_flat
);
  localparam logic [RRPV_W-1:0] MAXV = {RRPV_W{1'b1}};

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    logic [RRPV_W-1:0] val_q;
    always_ff @(posedge clk) begin
      if (rst)                                       val_q <= MAXV;
      else if (age_en && val_q != MAXV)              val_q <= val_q + 1'b1;
      else if (fill_en && fill_way == WAY_W'(g))     val_q <= fill_val;
      else if (clr_en && clr_way == WAY_W'(g))       val_q <= '0;
    end
    assign rrpv_flat[g*RRPV_W +: RRPV_W] = val_q;

    // R4: aging is only requested while no way sits at the distant value
    assert_age_R4: assert property (@(posedge clk) disable iff (rst)
      age_en |-> (val_q != MAXV));
  end
endmodule

// File: rtl/pa_rrip_ctrl.sv
module pa_rrip_ctrl
  import pa_rrip_pkg::*;
#(
  parameter int WAYS   = 16,
  parameter int RRPV_W = 2,
  parameter int WAY_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              req_valid,
  input  logic              req_prefetch,
  input  logic              req_hit,
  input  logic [WAY_W-1:0]  req_way,
  input  logic [WAYS-1:0]   line_valid,
  input  logic              found,
  input  logic [WAY_W-1:0]  found_way,
  input  logic              need_age,
  output logic [WAYS-1:0]   vmask,
  output logic              busy,
  output logic              age_en,
  output logic              fill_en,
  output logic [WAY_W-1:0]  fill_way,
  output logic [RRPV_W-1:0] fill_val,
  output logic              clr_en,
  output logic [WAY_W-1:0]  clr_way,
  output logic              victim_valid,
  output logic [WAY_W-1:0]  victim_way
);
  localparam logic [RRPV_W-1:0] MAXV = {RRPV_W{1'b1}};
  localparam logic [RRPV_W-1:0] DEMV = MAXV - 1'b1;

  srch_state_e state_q;
  logic        pf_q;
  pf_mode_e    mode_q;
  logic        accept;
  pf_mode_e    mode_in;

  assign mode_in = pf_mode_e'(mode);
  assign accept  = req_valid && (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      pf_q         <= 1'b0;
      mode_q       <= MODE_BASE;
      vmask        <= '0;
      victim_valid <= 1'b0;
      victim_way   <= '0;
    end else begin
      victim_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept && !req_hit) begin
            state_q <= ST_SEARCH;
            pf_q    <= req_prefetch;
            mode_q  <= mode_in;
            vmask   <= line_valid;
          end
        end
        ST_SEARCH: begin
          if (found) begin
            state_q      <= ST_IDLE;
            victim_valid <= 1'b1;
            victim_way   <= found_way;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy     = (state_q == ST_SEARCH);
    age_en   = busy && need_age;
    fill_en  = busy && found;
    fill_way = found_way;
    fill_val = (pf_q && (mode_q == MODE_MISS || mode_q == MODE_BOTH)) ? MAXV : DEMV;
    clr_en   = accept && req_hit &&
               (!req_prefetch || mode_in == MODE_BASE || mode_in == MODE_MISS);
    clr_way  = req_way;
  end

  // R5: the victim pulse is one cycle wide
  assert_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    victim_valid |=> !victim_valid);
  // R5: a pulse only follows a cycle spent searching
  assert_busy_R5: assert property (@(posedge clk) disable iff (rst)
    victim_valid |-> $past(busy));
endmodule

// File: rtl/pa_rrip_set.sv
module pa_rrip_set
  import pa_rrip_pkg::*;
#(
  parameter int WAYS   = 16,
  parameter int RRPV_W = 2,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             mode,
  input  logic                   req_valid,
  input  logic                   req_prefetch,
  input  logic                   req_hit,
  input  logic [WAY_W-1:0]       req_way,
  input  logic [WAYS-1:0]        line_valid,
  output logic                   busy,
  output logic                   victim_valid,
  output logic [WAY_W-1:0]       victim_way,
  output logic [WAYS*RRPV_W-1:0] rrpv_o
);
  localparam logic [RRPV_W-1:0] MAXV = {RRPV_W{1'b1}};

  logic              found, need_age;
  logic [WAY_W-1:0]  found_way;
  logic [WAYS-1:0]   vmask;
  logic              age_en, fill_en, clr_en;
  logic [WAY_W-1:0]  fill_way, clr_way;
  logic [RRPV_W-1:0] fill_val;

  pa_rrip_vsel #(.WAYS(WAYS), .RRPV_W(RRPV_W), .WAY_W(WAY_W)) u_vsel (
    .rrpv_flat(rrpv_o), .valid(vmask),
    .found(found), .found_way(found_way), .need_age(need_age)
  );

  pa_rrip_ctrl #(.WAYS(WAYS), .RRPV_W(RRPV_W), .WAY_W(WAY_W)) u_ctrl (
    .clk(clk), .rst(rst), .mode(mode),
    .req_valid(req_valid), .req_prefetch(req_prefetch), .req_hit(req_hit),
    .req_way(req_way), .line_valid(line_valid),
    .found(found), .found_way(found_way), .need_age(need_age),
    .vmask(vmask), .busy(busy), .age_en(age_en),
    .fill_en(fill_en), .fill_way(fill_way), .fill_val(fill_val),
    .clr_en(clr_en), .clr_way(clr_way),
    .victim_valid(victim_valid), .victim_way(victim_way)
  );

  pa_rrip_array #(.WAYS(WAYS), .RRPV_W(RRPV_W), .WAY_W(WAY_W)) u_array (
    .clk(clk), .rst(rst), .age_en(age_en),
    .fill_en(fill_en), .fill_way(fill_way), .fill_val(fill_val),
    .clr_en(clr_en), .clr_way(clr_way), .rrpv_flat(rrpv_o)
  );

  logic [RRPV_W-1:0] req_way_val, victim_val;
  assign req_way_val = rrpv_o[req_way*RRPV_W +: RRPV_W];
  assign victim_val  = rrpv_o[victim_way*RRPV_W +: RRPV_W];

  // R8: an accepted demand hit leaves its way at 0
  assert_demand_hit_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_hit && !req_prefetch && !busy) |=>
      (rrpv_o[$past(req_way)*RRPV_W +: RRPV_W] == '0));
  // R8: a prefetch hit in hit or both mode keeps the way's value
  assert_pf_hit_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_hit && req_prefetch && !busy && mode[1]) |=>
      (rrpv_o[$past(req_way)*RRPV_W +: RRPV_W] == $past(req_way_val)));
  // R6: a filled way always sits at one of the two insertion values
  assert_insert_R6: assert property (@(posedge clk) disable iff (rst)
    victim_valid |-> (victim_val >= MAXV - 1'b1));
  // R9: nothing is accepted while a search runs
  assert_ignore_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && !$past(busy)) |-> $past(req_valid && !req_hit));
endmodule

// File: tb/pa_rrip_set_tb.sv
module pa_rrip_set_tb;
  localparam int WAYS = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  mode;
  logic        req_valid, req_prefetch, req_hit;
  logic [3:0]  req_way;
  logic [15:0] line_valid;
  logic        busy, victim_valid;
  logic [3:0]  victim_way;
  logic [31:0] rrpv_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  pa_rrip_set u_dut (
    .clk(clk), .rst(rst), .mode(mode), .req_valid(req_valid),
    .req_prefetch(req_prefetch), .req_hit(req_hit), .req_way(req_way),
    .line_valid(line_valid), .busy(busy), .victim_valid(victim_valid),
    .victim_way(victim_way), .rrpv_o(rrpv_o)
  );

  function automatic int val(input int w);
    return int'(rrpv_o[w*2 +: 2]);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_vals(input string req, input int exp [WAYS]);
    for (int w = 0; w < WAYS; w++) check(req, val(w), exp[w]);
  endtask

  task automatic do_hit(input int w, input logic pf, input logic [1:0] md);
    @(negedge clk);
    mode = md; req_valid = 1'b1; req_hit = 1'b1; req_prefetch = pf; req_way = 4'(w);
    @(negedge clk);
    req_valid = 1'b0; req_hit = 1'b0;
  endtask

  // returns victim way and number of negedges after the request cycle
  task automatic do_miss(input logic pf, input logic [1:0] md, input logic [15:0] vm,
                         output int way, output int lat);
    @(negedge clk);
    mode = md; req_valid = 1'b1; req_hit = 1'b0; req_prefetch = pf; line_valid = vm;
    lat = 0; way = -1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      lat++;
      if (victim_valid) begin way = int'(victim_way); break; end
    end
    line_valid = 16'hFFFF;
  endtask

  task automatic t_reset;
    int exp [WAYS];
    for (int w = 0; w < WAYS; w++) exp[w] = 3;
    check_vals("R1", exp);
    check("R1 busy", int'(busy), 0);
    check("R1 victim_valid", int'(victim_valid), 0);
  endtask

  task automatic t_invalid;
    int way, lat;
    do_miss(1'b0, 2'd0, 16'hFDDF, way, lat);
    check("R2 invalid way first", way, 5);
    check("R6 demand fill", val(5), 2);
  endtask

  task automatic t_lowest;
    int way, lat;
    do_miss(1'b0, 2'd0, 16'hFFFF, way, lat);
    check("R3 lowest distant", way, 0);
    check("R4 no aging latency", lat, 2);
    check("R6 demand fill", val(0), 2);
  endtask

  task automatic t_insert;
    int way, lat;
    do_miss(1'b1, 2'd1, 16'hFFFF, way, lat);
    check("R3 victim", way, 1);
    check("R6 prefetch fill miss mode", val(1), 3);
    do_miss(1'b1, 2'd2, 16'hFFFF, way, lat);
    check("R3 victim", way, 1);
    check("R6 prefetch fill hit mode", val(1), 2);
    do_miss(1'b1, 2'd3, 16'hFFFF, way, lat);
    check("R3 victim", way, 2);
    check("R6 prefetch fill both mode", val(2), 3);
    do_miss(1'b1, 2'd0, 16'hFFFF, way, lat);
    check("R3 victim", way, 2);
    check("R6 prefetch fill baseline", val(2), 2);
  endtask

  task automatic t_hit_base;
    int exp [WAYS];
    for (int w = 0; w < WAYS; w++) exp[w] = val(w);
    do_hit(7, 1'b0, 2'd0);  exp[7] = 0;
    do_hit(8, 1'b1, 2'd0);  exp[8] = 0;
    do_hit(9, 1'b1, 2'd1);  exp[9] = 0;
    check_vals("R7", exp);
  endtask

  task automatic t_hit_h;
    int exp [WAYS];
    for (int w = 0; w < WAYS; w++) exp[w] = val(w);
    do_hit(10, 1'b1, 2'd2);
    check_vals("R8 prefetch hit hit-mode", exp);
    do_hit(11, 1'b1, 2'd3);
    check_vals("R8 prefetch hit both-mode", exp);
    do_hit(10, 1'b0, 2'd2); exp[10] = 0;
    do_hit(11, 1'b0, 2'd3); exp[11] = 0;
    check_vals("R8 demand hit", exp);
  endtask

  task automatic t_aging;
    int way, lat;
    int exp [WAYS];
    for (int w = 0; w < WAYS; w++) do_hit(w, 1'b0, 2'd0);
    do_miss(1'b0, 2'd0, 16'hFFFF, way, lat);
    check("R4 aged victim", way, 0);
    check("R4 three-step latency", lat, 5);
    for (int w = 0; w < WAYS; w++) exp[w] = (w == 0) ? 2 : 3;
    check_vals("R4 after aging", exp);
    for (int w = 1; w < WAYS; w++) do_hit(w, 1'b0, 2'd0);
    do_miss(1'b0, 2'd0, 16'hFFFF, way, lat);
    check("R4 mixed victim", way, 0);
    check("R4 one-step latency", lat, 3);
    for (int w = 0; w < WAYS; w++) exp[w] = (w == 0) ? 2 : 1;
    check_vals("R4 relative order kept", exp);
  endtask

  task automatic t_busy;
    int pulses = 0;
    int exp [WAYS];
    // state: way0=2, others 1 -> one aging step, then fill way0
    @(negedge clk);
    mode = 2'd0; req_valid = 1'b1; req_hit = 1'b0; req_prefetch = 1'b0;
    @(negedge clk);
    check("R5 busy after accept", int'(busy), 1);
    req_hit = 1'b1; req_way = 4'd4;
    @(negedge clk);
    if (victim_valid) pulses++;
    req_hit = 1'b0;
    @(negedge clk);
    if (victim_valid) pulses++;
    req_valid = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (victim_valid) pulses++;
    end
    check("R9 single pulse", pulses, 1);
    for (int w = 0; w < WAYS; w++) exp[w] = 2;
    check_vals("R9 hit ignored", exp);
  endtask

  initial begin
    rst = 1'b1; mode = 2'd0; req_valid = 1'b0; req_prefetch = 1'b0;
    req_hit = 1'b0; req_way = '0; line_valid = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_invalid();
    t_lowest();
    t_insert();
    t_hit_base();
    t_hit_h();
    t_aging();
    t_busy();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule